// File: doc/BRIEF.md
# BlaMka Quarter-Round Pipeline

This block computes one BlaMka quarter-round on four 64-bit words. It uses the same order of add, XOR and rotate steps as a classic ARX quarter-round. Each plain modular add is replaced by a multiply-augmented add. That add sums the two operands and twice the product of their low 32-bit halves, modulo 2^64.

The datapath is an eight-stage register pipeline, with one register stage per step:
- four multiply-add stages;
- four XOR-and-rotate stages.

Words enter on a valid/ready input handshake and leave on a valid/ready output handshake. All stages advance together. When the last stage holds a result that the consumer has not yet taken, the whole pipeline freezes, and a new input is refused for that cycle.

Top module: `blamka_qr_pipe`

## Requirements
- R1: `in_ready` is low exactly in the cycles where `out_valid` is high and `out_ready` is low. In every other cycle it is high.
- R2: While `rst` is high, every valid flag is cleared. Starting the cycle after reset is first sampled, `out_valid` is low and stays low until a new input has passed through the pipeline. Inputs in flight at reset are dropped.
- R3: If `out_ready` stays high, the result of a word set accepted on a clock edge is presented with `out_valid` high exactly 8 clock edges later.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and all four output words hold their values from one cycle to the next.
- R5: Every add step computes f(x,y) = x + y + 2·(x[31:0]·y[31:0]) mod 2^64, with both low halves taken as unsigned.
- R6: The first half runs in this order: a ← f(a,b), then d ← rotr(d^a, 32), then c ← f(c,d), then b ← rotr(b^c, 24).
- R7: The second half repeats the same order with rotate amounts 16 for d and 63 for b. Rotate right by 63 equals rotate left by 1.
- R8: An all-zero input gives an all-zero output.
- R9: An all-ones input on every word gives the value of the equations in R5 to R7, to the bit.
- R10: With `in_valid` and `out_ready` held high, one input is accepted and one result is produced on every clock edge.
- R11: Results leave in the order their inputs were accepted. No result appears without a matching input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid flags |
| in_valid | input | 1 | Input word set is present |
| in_ready | output | 1 | Block takes the input on this edge |
| in_a | input | 64 | Word a |
| in_b | input | 64 | Word b |
| in_c | input | 64 | Word c |
| in_d | input | 64 | Word d |
| out_valid | output | 1 | Result word set is present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_a | output | 64 | Updated word a |
| out_b | output | 64 | Updated word b |
| out_c | output | 64 | Updated word c |
| out_d | output | 64 | Updated word d |

## Verification
A word set accepted on an edge is due at the outputs 8 edges later, provided no stall intervenes. A stall adds exactly its own length. The driver records the cycle of each acceptance next to the model result it pushes into the scoreboard. In the phases where `out_ready` is held high, the monitor requires each popped result to appear exactly 8 cycles after that record. In the phases with random back-pressure, it checks only order and value, and requires the outputs to hold steady across each stalled cycle. Inputs are driven, and outputs sampled, one nanosecond after the falling edge, so every transfer is judged before the rising edge that completes it.

// File: rtl/blamka_pkg.sv
package blamka_pkg;

  parameter int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int N_STEPS = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  typedef enum logic [1:0] {
    LANE_A = 2'd0,
    LANE_B = 2'd1,
    LANE_C = 2'd2,
    LANE_D = 2'd3
  } lane_e;

  typedef enum logic {
    STEP_MIX  = 1'b0,
    STEP_XROT = 1'b1
  } step_e;

  // Step k of the quarter-round: even steps are multiply-adds, odd steps XOR-rotate.
  function automatic step_e step_kind(input int k);
    return (k % 2 == 0) ? STEP_MIX : STEP_XROT;
  endfunction

  // Destination lane of step k: a, d, c, b, then repeat.
  function automatic lane_e step_dst(input int k);
    case (k % 4)
      0: return LANE_A;
      1: return LANE_D;
      2: return LANE_C;
      default: return LANE_B;
    endcase
  endfunction

  // Source lane of step k: b, a, d, c, then repeat.
  function automatic lane_e step_src(input int k);
    case (k % 4)
      0: return LANE_B;
      1: return LANE_A;
      2: return LANE_D;
      default: return LANE_C;
    endcase
  endfunction

  // Rotate amount of step k. Only odd steps use it.
  function automatic int step_rot(input int k);
    case (k)
      1: return 32;
      3: return 24;
      5: return 16;
      7: return 63;
      default: return 0;
    endcase
  endfunction

  function automatic word_t lane_get(input quad_t q, input lane_e sel);
    case (sel)
      LANE_A: return q.a;
      LANE_B: return q.b;
      LANE_C: return q.c;
      default: return q.d;
    endcase
  endfunction

  function automatic quad_t lane_put(input quad_t q, input lane_e sel, input word_t v);
    quad_t r;
    r = q;
    case (sel)
      LANE_A: r.a = v;
      LANE_B: r.b = v;
      LANE_C: r.c = v;
      default: r.d = v;
    endcase
    return r;
  endfunction

  // Multiply-augmented add, given the low-half product precomputed.
  function automatic word_t mix_add(input word_t x, input word_t y, input word_t lo_prod);
    return x + y + {lo_prod[WORD_W-2:0], 1'b0};
  endfunction

  function automatic word_t rot_right(input word_t v, input int n);
    word_t r;
    r = v;
    for (int i = 0; i < WORD_W; i++) begin
      r[i] = v[(i + n) % WORD_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/blamka_mul_lo.sv
module blamka_mul_lo #(
  parameter int OP_W   = 32,
  parameter int LIMB_W = 16
) (
  input  logic [OP_W-1:0]   op_x,
  input  logic [OP_W-1:0]   op_y,
  output logic [2*OP_W-1:0] product
);
  localparam int N_LIMB = OP_W / LIMB_W;
  localparam int PROD_W = 2 * OP_W;
  localparam int PART_W = 2 * LIMB_W;
  localparam int N_PART = N_LIMB * N_LIMB;

  logic [PROD_W-1:0] partial [N_PART];

  generate
    for (genvar i = 0; i < N_LIMB; i++) begin : g_row
      for (genvar j = 0; j < N_LIMB; j++) begin : g_col
        logic [PART_W-1:0] pp;
        assign pp = PART_W'(op_x[i*LIMB_W +: LIMB_W]) * PART_W'(op_y[j*LIMB_W +: LIMB_W]);
        assign partial[i*N_LIMB + j] = PROD_W'(pp) << ((i + j) * LIMB_W);
      end
    end
  endgenerate

  always_comb begin
    product = '0;
    for (int k = 0; k < N_PART; k++) begin
      product = product + partial[k];
    end
  end

endmodule

// File: rtl/blamka_stage.sv
module blamka_stage
  import blamka_pkg::*;
#(
  parameter step_e KIND = STEP_MIX,
  parameter lane_e DST  = LANE_A,
  parameter lane_e SRC  = LANE_B,
  parameter int    ROT  = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  v_in,
  input  quad_t q_in,
  output logic  v_out,
  output quad_t q_out
);
  word_t dst_w;
  word_t src_w;
  word_t new_w;
  quad_t q_next;
  logic  step_fire;

  assign dst_w     = lane_get(q_in, DST);
  assign src_w     = lane_get(q_in, SRC);
  assign step_fire = adv && v_in;

  generate
    if (KIND == STEP_MIX) begin : g_mix
      logic [WORD_W-1:0] lo_prod;
      blamka_mul_lo #(.OP_W(HALF_W), .LIMB_W(HALF_W / 2)) u_mul (
        .op_x    (dst_w[HALF_W-1:0]),
        .op_y    (src_w[HALF_W-1:0]),
        .product (lo_prod)
      );
      assign new_w = mix_add(dst_w, src_w, lo_prod);
    end else begin : g_xrot
      assign new_w = rot_right(dst_w ^ src_w, ROT);
    end
  endgenerate

  assign q_next = lane_put(q_in, DST, new_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
    end else if (adv) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      q_out <= q_next;
    end
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> v_out) else $error("stage lost a valid item"); // R3

  AST_STAGE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(v_out)) else $error("stage moved while frozen"); // R4

endmodule

// File: rtl/blamka_qr_pipe.sv
module blamka_qr_pipe
  import blamka_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic [63:0] in_c,
  input  logic [63:0] in_d,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_a,
  output logic [63:0] out_b,
  output logic [63:0] out_c,
  output logic [63:0] out_d
);
  logic  vld [N_STEPS+1];
  quad_t dat [N_STEPS+1];
  logic  advance;
  logic  out_stalled;
  logic  in_accept;

  assign out_stalled = vld[N_STEPS] && !out_ready;
  assign advance     = !out_stalled;
  assign in_ready    = advance;
  assign in_accept   = in_valid && in_ready;

  assign vld[0] = in_valid;
  assign dat[0] = '{a: in_a, b: in_b, c: in_c, d: in_d};

  generate
    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
      blamka_stage #(
        .KIND (step_kind(k)),
        .DST  (step_dst(k)),
        .SRC  (step_src(k)),
        .ROT  (step_rot(k))
      ) u_stage (
        .clk   (clk),
        .rst   (rst),
        .adv   (advance),
        .v_in  (vld[k]),
        .q_in  (dat[k]),
        .v_out (vld[k+1]),
        .q_out (dat[k+1])
      );
    end
  endgenerate

  assign out_valid = vld[N_STEPS];
  assign out_a     = dat[N_STEPS].a;
  assign out_b     = dat[N_STEPS].b;
  assign out_c     = dat[N_STEPS].c;
  assign out_d     = dat[N_STEPS].d;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid) else $error("valid survived reset"); // R2

  AST_BLOCKED_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready) else $error("input taken while stalled"); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)
                                   && $stable(out_c) && $stable(out_d)))
    else $error("output changed while stalled"); // R4

  AST_FIRST_STAGE_TAKES: assert property (@(posedge clk) disable iff (rst)
    in_accept |=> g_step[0].u_stage.v_out) else $error("accepted input dropped"); // R10

endmodule

// File: tb/sim_blamka_qr_pipe.sv
module sim_blamka_qr_pipe;

  localparam int LAT = 8;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_a, in_b, in_c, in_d;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_a, out_b, out_c, out_d;

  always #5 clk = ~clk;

  blamka_qr_pipe u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit lat_chk = 1'b0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [255:0] exp_q[$];
  int           ts_q[$];
  int first_out, last_out, n_out_burst;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference written from the equations: product on zero-extended low halves.
  function automatic logic [63:0] ref_f(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] p;
    p = {32'h0, x[31:0]} * {32'h0, y[31:0]};
    return x + y + p + p;
  endfunction

  function automatic logic [63:0] ref_ror(input logic [63:0] v, input int n);
    logic [127:0] t;
    t = {v, v} >> n;
    return t[63:0];
  endfunction

  function automatic logic [255:0] ref_qr(input logic [63:0] a0, b0, c0, d0);
    logic [63:0] a, b, c, d;
    a = a0; b = b0; c = c0; d = d0;
    a = ref_f(a, b); d = ref_ror(d ^ a, 32);
    c = ref_f(c, d); b = ref_ror(b ^ c, 24);
    a = ref_f(a, b); d = ref_ror(d ^ a, 16);
    c = ref_f(c, d); b = ref_ror(b ^ c, 63);
    return {a, b, c, d};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; pushes the model result when the input is taken.
  task automatic drive(input bit iv, input logic [63:0] a, b, c, d, input bit ordy);
    @(negedge clk);
    in_valid = iv; in_a = a; in_b = b; in_c = c; in_d = d;
    out_ready = ordy;
    #1;
    if (iv && in_ready) begin
      exp_q.push_back(ref_qr(a, b, c, d));
      ts_q.push_back(cyc);
    end
  endtask

  // Monitor: pops and compares every transfer, watches stalls.
  logic        prev_stall = 1'b0;
  logic [255:0] prev_out;
  always @(negedge clk) begin
    #1;
    if (mon_en && !rst) begin
      check(in_ready == !(out_valid && !out_ready), "R1 in_ready rule",
            {255'h0, in_ready}, {255'h0, !(out_valid && !out_ready)});
      if (prev_stall) begin
        check(out_valid && ({out_a, out_b, out_c, out_d} == prev_out), "R4 hold while stalled",
              {out_a, out_b, out_c, out_d}, prev_out);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 result without input", {out_a, out_b, out_c, out_d}, '0);
        end else begin
          logic [255:0] e;
          int t;
          e = exp_q.pop_front();
          t = ts_q.pop_front();
          check({out_a, out_b, out_c, out_d} == e, "R5 R6 R7 R11 result", {out_a, out_b, out_c, out_d}, e);
          if (lat_chk) begin
            check(cyc - t == LAT, "R3 latency", 256'(cyc - t), 256'(LAT));
          end
          if (n_out_burst == 0) first_out = cyc;
          last_out = cyc;
          n_out_burst++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out = {out_a, out_b, out_c, out_d};
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0) && guard < 200) begin
      drive(1'b0, '0, '0, '0, '0, 1'b1);
      guard++;
    end
    check(exp_q.size() == 0, "R11 all results delivered", 256'(exp_q.size()), '0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; in_d = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R2 reset out_valid", {255'h0, out_valid}, '0);
    check(in_ready == 1'b1, "R2 reset in_ready", {255'h0, in_ready}, 256'h1);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;

    // Corner cases with a free-flowing output: R8, R9, R3.
    lat_chk = 1'b1;
    drive(1'b1, '0, '0, '0, '0, 1'b1);
    check(ref_qr('0, '0, '0, '0) == '0, "R8 zero model", ref_qr('0, '0, '0, '0), '0);
    drive(1'b1, '1, '1, '1, '1, 1'b1);
    drive(1'b1, 64'h1, 64'h0, 64'h0, 64'h0, 1'b1);
    drive(1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'h0, 64'h8000_0000_0000_0001, 1'b1);
    drain();

    // Zero input gives zero output at the port: R8.
    begin
      bit seen;
      seen = 1'b0;
      drive(1'b1, '0, '0, '0, '0, 1'b1);
      for (int i = 0; i < 12; i++) begin
        drive(1'b0, '0, '0, '0, '0, 1'b1);
        if (out_valid && !seen) begin
          seen = 1'b1;
          check({out_a, out_b, out_c, out_d} == '0, "R8 zero in zero out", {out_a, out_b, out_c, out_d}, '0);
        end
      end
      check(seen, "R8 zero result seen", {255'h0, seen}, 256'h1);
    end

    // All-ones compared against the value computed here: R9.
    begin
      bit seen;
      logic [255:0] e1;
      seen = 1'b0;
      e1 = ref_qr('1, '1, '1, '1);
      drive(1'b1, '1, '1, '1, '1, 1'b1);
      for (int i = 0; i < 12; i++) begin
        drive(1'b0, '0, '0, '0, '0, 1'b1);
        if (out_valid && !seen) begin
          seen = 1'b1;
          check({out_a, out_b, out_c, out_d} == e1, "R9 all ones", {out_a, out_b, out_c, out_d}, e1);
        end
      end
    end

    // Back-to-back stream: R10 throughput, R3 latency.
    n_out_burst = 0;
    for (int i = 0; i < 40; i++) begin
      drive(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1);
    end
    drain();
    check(n_out_burst == 40 && (last_out - first_out) == 39, "R10 one per cycle",
          256'(last_out - first_out), 256'(39));

    // Random back-pressure and gaps: R1, R4, R11.
    lat_chk = 1'b0;
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 3) != 0);
    end
    drain();

    // Reset with items in flight: R2.
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
    end
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    exp_q.delete(); ts_q.delete();
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R2 mid-run reset clears", {255'h0, out_valid}, '0);
    @(negedge clk);
    rst = 1'b0;
    begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 12; i++) begin
        drive(1'b0, '0, '0, '0, '0, 1'b1);
        if (out_valid) any = 1'b1;
      end
      check(!any, "R2 flushed items stay gone", {255'h0, any}, '0);
    end

    // Latency once more after reset: R3.
    lat_chk = 1'b1;
    drive(1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h5555_AAAA_5555_AAAA, 64'h0F0F_F0F0_0F0F_F0F0, 1'b1);
    drain();

    finish_run();
  end

endmodule